// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor

This block guesses where instruction fetch goes next while the instruction cache is still being read for the current fetch address. It holds two structures. The first is a small, fully associative store that keeps a target address only for branches that are expected to be taken. The second is a larger table of 2-bit saturating counters, selected directly by low fetch-address bits, that gives a direction guess to the decode stage.

Both structures are looked up at the same time, combinationally from the fetch PC. If the target store hits, the next fetch address is the stored target. Otherwise it is the fetch PC plus the fetch group size. When a branch resolves in execute, the resolution port updates both structures on the next clock edge:
- the counter always moves toward the actual outcome;
- a taken branch that misses the target store is allocated an entry;
- a taken branch that hits has its target refreshed;
- a not-taken branch that hits loses its entry.

Top module: `btp_fetch_predictor`

## Requirements
- R1: After reset no target entry is valid, so every lookup misses. Every direction counter holds 1 (weakly not-taken), so `pred_dir` is 0 for every PC.
- R2: When the target store misses, `pred_hit` is 0 and `next_pc` equals `fetch_pc + FETCH_BYTES`.
- R3: A resolved taken branch whose PC is not held in the target store is allocated an entry. From the next cycle, a lookup of that PC gives `pred_hit` = 1 and `pred_target` = the resolved target, and `next_pc` equals `pred_target`.
- R4: A resolved taken branch whose PC is already held overwrites that entry's target, and no second entry is created.
- R5: A resolved not-taken branch whose PC is held invalidates that entry, so later lookups of that PC miss. A resolved not-taken branch that is not held changes nothing in the target store.
- R6: Allocation takes the lowest-numbered free entry when one exists. When all entries are valid, the victim is chosen by a pointer that starts at entry 0 after reset and advances by one, wrapping, only on each replacement of a valid entry.
- R7: Each direction counter is 2 bits. It increments on a resolved taken branch and saturates at 3. It decrements on a resolved not-taken branch and saturates at 0. `pred_dir` is 1 when the counter is 2 or more. Counters update on every resolution, whether or not the target store hit.
- R8: The direction counter is selected by PC bits [log2(BHT_ENTRIES)+1:2]. PCs that share those bits share a counter.
- R9: Target-store tags compare the whole PC, so PCs that share index bits but differ in upper bits do not hit each other's entries.
- R10: An update and a lookup of the same PC in the same cycle return the contents from before the update. The update is visible from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Address of the current fetch group |
| pred_hit | output | 1 | Target store holds `fetch_pc` |
| pred_target | output | ADDR_W | Stored target on a hit, zero on a miss |
| next_pc | output | ADDR_W | Predicted next fetch address |
| pred_dir | output | 1 | Direction guess from the counter table (1 = taken) |
| upd_valid | input | 1 | A branch resolution is presented this cycle |
| upd_pc | input | ADDR_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch |
| upd_target | input | ADDR_W | Actual target of the resolved branch |

## Verification
The bench builds the block with 4 target entries, a 16-entry counter table, 32-bit addresses and a 16-byte fetch group. With four entries, the store fills after a handful of resolutions. This brings the replacement pointer's wrap, the preference for a free slot over the pointer, and pointer advance only on replacement within a short run. With sixteen counters, PCs 0x100 and 0x1100 land on the same counter while keeping different tags. This exercises counter sharing and full-PC tag compare together, and lets the bench drive one counter to both saturation limits.

// File: rtl/btp_pkg.sv
package btp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_NT = 2'd1;

    function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken && cur != 2'd3) begin
            nxt = cur + 2'd1;
        end else if (!taken && cur != 2'd0) begin
            nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/btp_dir_table.sv
module btp_dir_table
    import btp_pkg::*;
#(
    parameter int ENTRIES = 512,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] look_idx,
    output logic             look_taken,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken
);

    typedef struct packed {
        ctr_t [ENTRIES-1:0] ctr;
    } dir_state_t;

    dir_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (upd_valid) begin
            state_d.ctr[upd_idx] = ctr_step(state_q.ctr[upd_idx], upd_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                state_q.ctr[i] <= CTR_WEAK_NT;
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign look_taken = state_q.ctr[look_idx][1];

endmodule

// File: rtl/btp_target_cache.sv
module btp_target_cache #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 64,
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_pc,
    output logic              look_hit,
    output logic [ADDR_W-1:0] look_target,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    typedef struct packed {
        logic [ENTRIES-1:0]             vld;
        logic [ENTRIES-1:0][ADDR_W-1:0] tag;
        logic [ENTRIES-1:0][ADDR_W-1:0] tgt;
        logic [PTR_W-1:0]               rr;
    } tc_state_t;

    tc_state_t state_d, state_q;

    logic [ENTRIES-1:0] look_match;
    logic [ENTRIES-1:0] upd_match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign look_match[g] = state_q.vld[g] && (state_q.tag[g] == look_pc);
        assign upd_match[g]  = state_q.vld[g] && (state_q.tag[g] == upd_pc);
    end

    always_comb begin
        look_target = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (look_match[i]) begin
                look_target = look_target | state_q.tgt[i];
            end
        end
    end

    assign look_hit = |look_match;

    logic             free_found;
    logic [PTR_W-1:0] free_idx;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!free_found && !state_q.vld[i]) begin
                free_found = 1'b1;
                free_idx   = PTR_W'(i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        if (upd_valid) begin
            if (|upd_match) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (upd_match[i]) begin
                        if (upd_taken) begin
                            state_d.tgt[i] = upd_target;
                        end else begin
                            state_d.vld[i] = 1'b0;
                        end
                    end
                end
            end else if (upd_taken) begin
                if (free_found) begin
                    state_d.vld[free_idx] = 1'b1;
                    state_d.tag[free_idx] = upd_pc;
                    state_d.tgt[free_idx] = upd_target;
                end else begin
                    state_d.tag[state_q.rr] = upd_pc;
                    state_d.tgt[state_q.rr] = upd_target;
                    state_d.rr = (state_q.rr == PTR_W'(ENTRIES - 1)) ? '0
                                                                     : state_q.rr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/btp_fetch_predictor.sv
module btp_fetch_predictor #(
    parameter int ADDR_W       = 32,
    parameter int BTAC_ENTRIES = 64,
    parameter int BHT_ENTRIES  = 512,
    parameter int FETCH_BYTES  = 16,
    localparam int DIR_IDX_W = $clog2(BHT_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic [ADDR_W-1:0] pred_target,
    output logic [ADDR_W-1:0] next_pc,
    output logic              pred_dir,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_pc,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target
);

    btp_target_cache #(
        .ADDR_W  (ADDR_W),
        .ENTRIES (BTAC_ENTRIES)
    ) u_tc (
        .clk         (clk),
        .rst_n       (rst_n),
        .look_pc     (fetch_pc),
        .look_hit    (pred_hit),
        .look_target (pred_target),
        .upd_valid   (upd_valid),
        .upd_pc      (upd_pc),
        .upd_taken   (upd_taken),
        .upd_target  (upd_target)
    );

    btp_dir_table #(
        .ENTRIES (BHT_ENTRIES)
    ) u_dir (
        .clk        (clk),
        .rst_n      (rst_n),
        .look_idx   (fetch_pc[DIR_IDX_W+1:2]),
        .look_taken (pred_dir),
        .upd_valid  (upd_valid),
        .upd_idx    (upd_pc[DIR_IDX_W+1:2]),
        .upd_taken  (upd_taken)
    );

    assign next_pc = pred_hit ? pred_target : fetch_pc + ADDR_W'(FETCH_BYTES);

endmodule

// File: rtl/btp_fetch_predictor_chk.sv
module btp_fetch_predictor_chk #(
    parameter int ADDR_W      = 32,
    parameter int FETCH_BYTES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_hit,
    input logic [ADDR_W-1:0] pred_target,
    input logic [ADDR_W-1:0] next_pc,
    input logic              pred_dir,
    input logic              upd_valid,
    input logic [ADDR_W-1:0] upd_pc,
    input logic              upd_taken,
    input logic [ADDR_W-1:0] upd_target
);

    AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> next_pc == fetch_pc + ADDR_W'(FETCH_BYTES)); // R2

    AST_TAKEN_INSTALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
            (fetch_pc != $past(upd_pc)) ||
            (pred_hit && pred_target == $past(upd_target) && next_pc == $past(upd_target))); // R3

    AST_NOT_TAKEN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken) |=> (fetch_pc != $past(upd_pc)) || !pred_hit); // R5

    AST_DIR_HOLDS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken && fetch_pc == upd_pc && pred_dir) |=>
            (fetch_pc != $past(fetch_pc)) || pred_dir); // R7

    AST_DIR_HOLDS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && !upd_taken && fetch_pc == upd_pc && !pred_dir) |=>
            (fetch_pc != $past(fetch_pc)) || !pred_dir); // R7

endmodule

bind btp_fetch_predictor btp_fetch_predictor_chk #(
    .ADDR_W      (ADDR_W),
    .FETCH_BYTES (FETCH_BYTES)
) u_chk (.*);

// File: tb/sim_btp_fetch_predictor.sv
module sim_btp_fetch_predictor;

    localparam int AW = 32;
    localparam int FB = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_pc = '0;
    logic          pred_hit;
    logic [AW-1:0] pred_target;
    logic [AW-1:0] next_pc;
    logic          pred_dir;
    logic          upd_valid = 1'b0;
    logic [AW-1:0] upd_pc = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    btp_fetch_predictor #(
        .ADDR_W       (AW),
        .BTAC_ENTRIES (4),
        .BHT_ENTRIES  (16),
        .FETCH_BYTES  (FB)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .fetch_pc    (fetch_pc),
        .pred_hit    (pred_hit),
        .pred_target (pred_target),
        .next_pc     (next_pc),
        .pred_dir    (pred_dir),
        .upd_valid   (upd_valid),
        .upd_pc      (upd_pc),
        .upd_taken   (upd_taken),
        .upd_target  (upd_target)
    );

    typedef struct {
        logic [AW-1:0] pc;
        logic          hit;
        logic [AW-1:0] tgt;
        int            dir;   // 0, 1, or 2 for don't care
        string         req;
    } exp_t;

    exp_t sb[$];

    task automatic check(input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: pops one expectation per cycle at the falling edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(e.req, "pred_hit", AW'(pred_hit), AW'(e.hit));
            check(e.req, "next_pc", next_pc, e.hit ? e.tgt : e.pc + AW'(FB));
            if (e.hit) check(e.req, "pred_target", pred_target, e.tgt);
            if (e.dir != 2) check(e.req, "pred_dir", AW'(pred_dir), AW'(e.dir));
        end
    end

    // all tasks start and end 1 ns after a rising edge
    task automatic look(input logic [AW-1:0] pc, input logic hit,
                        input logic [AW-1:0] tgt, input int dir, input string req);
        exp_t e;
        fetch_pc = pc;
        e.pc = pc; e.hit = hit; e.tgt = tgt; e.dir = dir; e.req = req;
        sb.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic resolve(input logic [AW-1:0] pc, input logic taken,
                           input logic [AW-1:0] tgt);
        upd_valid = 1'b1; upd_pc = pc; upd_taken = taken; upd_target = tgt;
        @(posedge clk); #1;
        upd_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state, R2 sequential fall-through
        look(32'h100, 1'b0, '0, 0, "R1");
        look(32'h2000, 1'b0, '0, 0, "R2");

        // R3 allocation, R7 counter 1 -> 2
        resolve(32'h100, 1'b1, 32'h800);
        look(32'h100, 1'b1, 32'h800, 1, "R3");

        // R4 refresh target, counter -> 3
        resolve(32'h100, 1'b1, 32'h900);
        look(32'h100, 1'b1, 32'h900, 1, "R4");

        // R9 full tag compare, R8 shared counter (index 0)
        look(32'h1100, 1'b0, '0, 1, "R9");
        look(32'h1100, 1'b0, '0, 1, "R8");

        // R7 saturate at 3, then R5 invalidate on not-taken (counter 2)
        resolve(32'h100, 1'b1, 32'h900);
        resolve(32'h100, 1'b0, '0);
        look(32'h100, 1'b0, '0, 1, "R5");
        // counter 3 would need two steps to reach 1; seeing 1 proves saturation
        resolve(32'h100, 1'b0, '0);
        look(32'h100, 1'b0, '0, 0, "R7");
        resolve(32'h100, 1'b0, '0);
        resolve(32'h100, 1'b0, '0);
        // counter 0 saturated; taken -> 1 and re-allocated (independent structures)
        resolve(32'h100, 1'b1, 32'hA00);
        look(32'h100, 1'b1, 32'hA00, 0, "R7");
        resolve(32'h100, 1'b0, '0);
        look(32'h100, 1'b0, '0, 0, "R5");

        // R6 fill four entries, then round-robin replacement
        resolve(32'h1000, 1'b1, 32'h4000);
        resolve(32'h1004, 1'b1, 32'h4100);
        resolve(32'h1008, 1'b1, 32'h4200);
        resolve(32'h100C, 1'b1, 32'h4300);
        look(32'h1000, 1'b1, 32'h4000, 2, "R6");
        resolve(32'h1010, 1'b1, 32'h4400);
        look(32'h1000, 1'b0, '0, 2, "R6");
        look(32'h1004, 1'b1, 32'h4100, 2, "R6");
        look(32'h1010, 1'b1, 32'h4400, 2, "R6");
        resolve(32'h1014, 1'b1, 32'h4500);
        look(32'h1004, 1'b0, '0, 2, "R6");
        look(32'h1008, 1'b1, 32'h4200, 2, "R6");

        // R6 free slot preferred, pointer unchanged by free-slot fill
        resolve(32'h1008, 1'b0, '0);
        resolve(32'h1018, 1'b1, 32'h4600);
        look(32'h1018, 1'b1, 32'h4600, 2, "R6");
        resolve(32'h101C, 1'b1, 32'h4700);
        look(32'h1018, 1'b0, '0, 2, "R6");
        look(32'h100C, 1'b1, 32'h4300, 2, "R6");
        look(32'h101C, 1'b1, 32'h4700, 2, "R6");

        // R5 not-taken miss leaves store unchanged
        resolve(32'h2220, 1'b0, '0);
        look(32'h1010, 1'b1, 32'h4400, 2, "R5");
        look(32'h1014, 1'b1, 32'h4500, 2, "R5");

        // R10 same-cycle update and lookup see old contents
        fetch_pc = 32'h3000;
        begin
            exp_t e;
            e.pc = 32'h3000; e.hit = 1'b0; e.tgt = '0; e.dir = 2; e.req = "R10";
            sb.push_back(e);
        end
        resolve(32'h3000, 1'b1, 32'h5000);
        look(32'h3000, 1'b1, 32'h5000, 2, "R10");

        @(posedge clk); #1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule